// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block watches a small group of asynchronous interrupt pins and turns each one into a clean, per-line request for a parent interrupt controller. Every pin first passes through a two-flop synchroniser. A per-line trigger unit then applies one of five conditions: rising edge, falling edge, both edges, active-high level or active-low level. When the condition is met, it sets a pending bit. A line's request output is high only while that line is both pending and enabled.

All software-visible state sits in one register word. The word is cut into six fields of `FIELD_W` bits each, and line `n` owns bit `n` of every field. Counted from bit 0, the fields are: trigger polarity (index 0), pending status (1), acknowledge (2), enable (3), dual-edge (4) and level-select (5). Field `k` starts at bit `k*FIELD_W`.

Access is a single-cycle write strobe plus a combinational read word. The block has no streaming data path, so it has no valid/ready handshake. Every pin is plain control or status.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset, the register word reads 0 and every request output is 0.
- R2: A write stores the polarity, enable, dual-edge and level-select bits of each line at bit `k*FIELD_W+n`, and they read back from those positions. The acknowledge field always reads 0. The status field is read-only. Bits outside the six fields, and field bits at or above `NUM_LINES`, ignore writes and read 0.
- R3: With dual-edge=0, level-select=0 and polarity=0, a rising pin edge sets the line's pending bit. The bit stays set after the pin returns low.
- R4: With dual-edge=0, level-select=0 and polarity=1, a falling edge sets pending and a rising edge does not.
- R5: With dual-edge=1, both edges set pending, and the polarity and level-select bits have no effect.
- R6: With dual-edge=0, level-select=1 and polarity=1, pending is 1 while the pin is high and 0 while it is low.
- R7: With dual-edge=0, level-select=1 and polarity=0, pending is 1 while the pin is low.
- R8: Request output `n` equals pending bit `n` AND enable bit `n`. The status field shows pending bits whatever their enables are.
- R9: In an edge mode, writing 1 to a line's acknowledge bit clears that line's pending bit in the write cycle. Other lines are left unchanged.
- R10: In a level mode, an acknowledge does not clear pending while the level is still active. Pending drops by itself once the level goes inactive.
- R11: A pin change reaches the request output on the third rising clock edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| reg_wr_en_i | input | 1 | Register write strobe, sampled on the rising edge |
| reg_wr_data_i | input | REG_W | Register write data |
| reg_rd_data_o | output | REG_W | Current register word |
| irq_o | output | NUM_LINES | Per-line request toward the parent controller |

## Verification
The bench builds the block with `NUM_LINES=4` and `FIELD_W=5`. A field stride that is not a power of two puts every field at a shifted offset. It also leaves one spare bit inside each field, plus two spare bits at the top of the word, so the decoding and the write-ignore rule are exercised at non-trivial positions. With four lines, all five trigger modes and the per-line isolation of acknowledge and enable can be tested side by side. Each check is sampled one cycle before and at the cycle when a pin change first becomes visible.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;
  // Field indices inside the shared register word; the offset of each field is index * FIELD_W.
  localparam int FLD_SENSE  = 0;
  localparam int FLD_STATUS = 1;
  localparam int FLD_CLEAR  = 2;
  localparam int FLD_MASK   = 3;
  localparam int FLD_BOTH   = 4;
  localparam int FLD_LEVEL  = 5;
  localparam int NUM_FIELDS = 6;

  typedef enum logic [2:0] {
    TRIG_RISE,
    TRIG_FALL,
    TRIG_BOTH,
    TRIG_LVL_HI,
    TRIG_LVL_LO
  } trig_mode_e;

  typedef struct packed {
    logic sense;
    logic both_edge;
    logic level;
  } line_cfg_t;

  // The dual-edge bit overrides the other two; level-select then picks between edge and level.
  function automatic trig_mode_e decode_mode(line_cfg_t c);
    if (c.both_edge)  return TRIG_BOTH;
    else if (c.level) return c.sense ? TRIG_LVL_HI : TRIG_LVL_LO;
    else              return c.sense ? TRIG_FALL : TRIG_RISE;
  endfunction
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
  parameter int NUM_LINES = 4,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] async_i,
  output logic [NUM_LINES-1:0] sync_o
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i[n]};
    end
    assign sync_o[n] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/eirq_line.sv
`timescale 1ns/1ps
module eirq_line
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_i,
  input  line_cfg_t cfg_i,
  input  logic      clr_i,
  output logic      pend_o
);
  trig_mode_e mode;
  logic prev_q, pend_q;
  logic edge_now, active_now, lvl_eff;

  assign mode = decode_mode(cfg_i);

  always_comb begin
    edge_now   = 1'b0;
    active_now = 1'b0;
    lvl_eff    = 1'b0;
    case (mode)
      TRIG_RISE:   edge_now = sync_i & ~prev_q;
      TRIG_FALL:   edge_now = ~sync_i & prev_q;
      TRIG_BOTH:   edge_now = sync_i ^ prev_q;
      TRIG_LVL_HI: begin lvl_eff = 1'b1; active_now = sync_i;  end
      TRIG_LVL_LO: begin lvl_eff = 1'b1; active_now = ~sync_i; end
      default:     edge_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      if (lvl_eff) pend_q <= active_now;
      else         pend_q <= edge_now | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;

  // R3: an edge-mode pending bit survives until it is acknowledged
  assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i && !lvl_eff) |=> (pend_q || lvl_eff));

  // R10: in a level mode an active level keeps pending set regardless of acknowledge
  assert_level_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_eff && active_now) |=> pend_q);

  // R9: acknowledge without a coincident edge empties the pending bit
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_eff && clr_i && !edge_now) |=> !pend_q);
endmodule

// File: rtl/eirq_regs.sv
`timescale 1ns/1ps
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int FIELD_W   = 4,
  parameter int REG_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [REG_W-1:0]            wr_data_i,
  input  logic [NUM_LINES-1:0]        status_i,
  output line_cfg_t [NUM_LINES-1:0]   cfg_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic [NUM_LINES-1:0]        clr_o,
  output logic [REG_W-1:0]            rd_data_o
);
  localparam int BASE_SENSE  = FLD_SENSE  * FIELD_W;
  localparam int BASE_STATUS = FLD_STATUS * FIELD_W;
  localparam int BASE_CLEAR  = FLD_CLEAR  * FIELD_W;
  localparam int BASE_MASK   = FLD_MASK   * FIELD_W;
  localparam int BASE_BOTH   = FLD_BOTH   * FIELD_W;
  localparam int BASE_LEVEL  = FLD_LEVEL  * FIELD_W;

  logic [NUM_LINES-1:0] sense_q, mask_q, both_q, level_q;
  logic [NUM_LINES-1:0] wr_sense, wr_mask, wr_both, wr_level, wr_clear;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_fld
    assign wr_sense[n] = wr_data_i[BASE_SENSE + n];
    assign wr_mask[n]  = wr_data_i[BASE_MASK  + n];
    assign wr_both[n]  = wr_data_i[BASE_BOTH  + n];
    assign wr_level[n] = wr_data_i[BASE_LEVEL + n];
    assign wr_clear[n] = wr_data_i[BASE_CLEAR + n];
    assign cfg_o[n]    = '{sense: sense_q[n], both_edge: both_q[n], level: level_q[n]};
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
      both_q  <= '0;
      level_q <= '0;
    end else if (wr_en_i) begin
      sense_q <= wr_sense;
      mask_q  <= wr_mask;
      both_q  <= wr_both;
      level_q <= wr_level;
    end
  end

  // Acknowledge is a pulse that lives only in the write cycle; nothing is stored.
  assign clr_o  = wr_en_i ? wr_clear : '0;
  assign mask_o = mask_q;

  always_comb begin
    rd_data_o = '0;
    for (int n = 0; n < NUM_LINES; n++) begin
      rd_data_o[BASE_SENSE  + n] = sense_q[n];
      rd_data_o[BASE_STATUS + n] = status_i[n];
      rd_data_o[BASE_MASK   + n] = mask_q[n];
      rd_data_o[BASE_BOTH   + n] = both_q[n];
      rd_data_o[BASE_LEVEL  + n] = level_q[n];
    end
  end

  // R2: configuration only moves on a write
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ($stable(sense_q) && $stable(mask_q) && $stable(both_q) && $stable(level_q)));
endmodule

// File: rtl/ext_irq_trigger.sv
`timescale 1ns/1ps
module ext_irq_trigger
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int FIELD_W   = 4,
  parameter int REG_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_pin_i,
  input  logic                 reg_wr_en_i,
  input  logic [REG_W-1:0]     reg_wr_data_i,
  output logic [REG_W-1:0]     reg_rd_data_o,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int SYNC_STAGES = 2;
  localparam int BASE_STATUS = FLD_STATUS * FIELD_W;

  logic [NUM_LINES-1:0]      pin_sync, pend, mask, clr;
  line_cfg_t [NUM_LINES-1:0] cfg;

  eirq_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (irq_pin_i),
    .sync_o  (pin_sync)
  );

  eirq_regs #(.NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (reg_wr_en_i),
    .wr_data_i (reg_wr_data_i),
    .status_i  (pend),
    .cfg_o     (cfg),
    .mask_o    (mask),
    .clr_o     (clr),
    .rd_data_o (reg_rd_data_o)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_trig
    eirq_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (pin_sync[n]),
      .cfg_i  (cfg[n]),
      .clr_i  (clr[n]),
      .pend_o (pend[n])
    );

    // R8: a request never appears without the matching status bit in the register word
    assert_out_has_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[n] |-> reg_rd_data_o[BASE_STATUS + n]);
  end

  assign irq_o = pend & mask;
endmodule

// File: tb/ext_irq_trigger_tb_top.sv
`timescale 1ns/1ps
module ext_irq_trigger_tb_top;
  localparam int NL = 4;
  localparam int FW = 5;
  localparam int RW = 32;

  typedef struct {
    logic [31:0] exp;
    bit          rd;
    string       req;
  } sb_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic [RW-1:0] rd_data;
  logic [NL-1:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  sb_item_t sb_q[$];

  always #2.5 clk = ~clk;

  ext_irq_trigger #(.NUM_LINES(NL), .FIELD_W(FW), .REG_W(RW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_pin_i     (pins),
    .reg_wr_en_i   (wr_en),
    .reg_wr_data_i (wr_data),
    .reg_rd_data_o (rd_data),
    .irq_o         (irq)
  );

  function automatic logic [31:0] cfgw(logic [3:0] s, logic [3:0] m, logic [3:0] b, logic [3:0] l);
    return 32'(s) | (32'(m) << (3*FW)) | (32'(b) << (4*FW)) | (32'(l) << (5*FW));
  endfunction
  function automatic logic [31:0] stw(logic [3:0] v);  return 32'(v) << FW;     endfunction
  function automatic logic [31:0] ackw(logic [3:0] v); return 32'(v) << (2*FW); endfunction

  // Monitor: pops each expected item and compares it against the live outputs.
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      act = it.rd ? rd_data : 32'(irq);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: %s actual=%h expected=%h", it.req, it.rd ? "rd_data" : "irq_o", act, it.exp);
      end
    end
  end

  task automatic expect_val(logic [31:0] exp, bit rd, string req);
    sb_item_t it;
    it.exp = exp; it.rd = rd; it.req = req;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic write_reg(logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drive_pins(logic [NL-1:0] v, int cyc);
    @(negedge clk);
    pins = v;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] c;
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_val(32'h0, 1, "R1 reset word");
    expect_val(32'h0, 0, "R1 reset outputs");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: write all ones, only defined bits stick, ack field reads 0
    write_reg(32'hFFFF_FFFF);
    expect_val(cfgw(4'hF, 4'hF, 4'hF, 4'hF), 1, "R2 field layout readback");
    write_reg(32'h0);
    expect_val(32'h0, 1, "R2 cleared readback");

    // R3 and R11: rising edge mode, latency and stickiness
    c = cfgw(4'h0, 4'hF, 4'h0, 4'h0);
    write_reg(c);
    drive_pins(4'b0001, 2);
    expect_val(32'h0, 0, "R11 not yet visible after two edges");
    @(negedge clk);
    expect_val(32'h1, 0, "R11 visible on third edge");
    drive_pins(4'b0000, 4);
    expect_val(32'h1, 0, "R3 pending sticky after pin low");
    expect_val(c | stw(4'h1), 1, "R3 status field");

    // R9: acknowledge one line only
    drive_pins(4'b0010, 3);
    drive_pins(4'b0000, 3);
    expect_val(32'h3, 0, "R9 two lines pending");
    write_reg(c | ackw(4'h1));
    expect_val(32'h2, 0, "R9 ack line0 only");
    write_reg(c | ackw(4'h2));
    expect_val(32'h0, 0, "R9 ack line1");
    expect_val(c, 1, "R9 ack bits read zero");

    // R4: falling edge mode
    c = cfgw(4'hF, 4'hF, 4'h0, 4'h0);
    write_reg(c);
    drive_pins(4'b0100, 4);
    expect_val(32'h0, 0, "R4 rising edge ignored");
    drive_pins(4'b0000, 3);
    expect_val(32'h4, 0, "R4 falling edge sets");
    write_reg(c | ackw(4'h4));
    expect_val(32'h0, 0, "R4 ack");

    // R5: dual edge overrides level-select and polarity
    c = cfgw(4'h0, 4'hF, 4'hF, 4'hF);
    write_reg(c);
    repeat (3) @(negedge clk);
    expect_val(32'h0, 0, "R5 level-low setting ignored");
    drive_pins(4'b1000, 3);
    expect_val(32'h8, 0, "R5 rising edge sets");
    write_reg(c | ackw(4'h8));
    expect_val(32'h0, 0, "R5 ack after rise");
    drive_pins(4'b0000, 3);
    expect_val(32'h8, 0, "R5 falling edge sets");
    write_reg(c | ackw(4'h8));

    // R6 and R10: active-high level
    c = cfgw(4'hF, 4'hF, 4'h0, 4'hF);
    write_reg(c);
    repeat (3) @(negedge clk);
    expect_val(32'h0, 0, "R6 low pin inactive");
    drive_pins(4'b0001, 3);
    expect_val(32'h1, 0, "R6 high pin active");
    write_reg(c | ackw(4'h1));
    expect_val(32'h1, 0, "R10 ack ignored while level active");
    drive_pins(4'b0000, 3);
    expect_val(32'h0, 0, "R10 pending drops with level");

    // R7: active-low level on all lines
    c = cfgw(4'h0, 4'hF, 4'h0, 4'hF);
    write_reg(c);
    repeat (3) @(negedge clk);
    expect_val(32'hF, 0, "R7 low pins active");
    drive_pins(4'b1111, 3);
    expect_val(32'h0, 0, "R7 high pins inactive");
    drive_pins(4'b0000, 3);

    // R8: enable gates output only
    c = cfgw(4'h0, 4'b0101, 4'h0, 4'hF);
    write_reg(c);
    repeat (3) @(negedge clk);
    expect_val(32'h5, 0, "R8 output gated by enable");
    expect_val(c | stw(4'hF), 1, "R8 status shows all pending");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule